// File: doc/BRIEF.md
# Destination Address Receive Filter with Multicast Hash

This block decides whether an incoming Ethernet frame should be kept, judging only by its 48-bit destination address. Software configures it through a small indirect register port: it writes an indirect pointer, then 16-bit data words that land in either the station address or a 512-entry one-bit multicast hash table. A separate 32-bit receive-mode word selects which address classes are let through.

For each frame the receive logic presents the destination address together with a one-cycle start strobe. The block runs a bit-serial reflected CRC-32 over the six address bytes, one bit per clock. It takes the low nine bits of the CRC as the hash index and then issues a one-cycle `done` pulse. With the pulse come an accept flag and a two-bit code that says why the frame was accepted. Byte k of the address (k = 0 travels first on the wire) is carried on `dst_addr[8k+7:8k]`.

Top module: `mcf_filter_top`

## Requirements
- R1: After reset `busy`, `done`, `accept` and `reason` are 0. The station address, hash table and mode flags are all cleared, so every frame is rejected until software configures the block.
- R2: The hash index is bits 8:0 of a CRC computed as follows. The register starts at 0xFFFFFFFF. Each bit b is taken in the order `dst_addr[0]` up to `dst_addr[47]`, and each step is crc = (crc >> 1) XOR (0xEDB88320 if crc[0] XOR b else 0). The final value is not inverted.
- R3: `reg_sel`=0 loads the indirect pointer from `reg_wdata[9:0]`. `reg_sel`=1 writes `reg_wdata[15:0]` to the location the pointer selects. Pointer 0x200 + 2*i (i = 0..31) writes table word i, and bit b of that word is hash entry 16*i + b.
- R4: Pointers 0, 2 and 4 write station address words 0, 1 and 2. Word w holds address byte 2w in bits 7:0 and byte 2w+1 in bits 15:8.
- R5: `reg_sel`=2 writes the mode word, which has these fields:
  - bit 31 or bit 30: accept broadcast
  - bit 29: all multicast
  - bit 28: all unicast (promiscuous)
  - bit 27: own station address
  - bit 21: hashed multicast
- R6: A destination of all ones is broadcast. Otherwise `dst_addr[0]`=1 marks multicast, and anything else is unicast.
- R7: A unicast frame is accepted when the all-unicast flag is set, or when the own-address flag is set and the destination equals the station address.
- R8: A multicast frame that is not broadcast is accepted when the all-multicast flag is set, or when the hashed-multicast flag is set and the table entry at the hash index is 1.
- R9: A broadcast frame is accepted exactly when bit 31 or bit 30 of the mode word is set. The other flags have no effect on a broadcast frame.
- R10: `reason` on an accepted frame is 0 for broadcast, 1 for exact station match, 2 for hash hit, and 3 for acceptance by the all-unicast or all-multicast flag. The all-unicast and all-multicast flags take priority over an exact match or a hash hit. A rejected frame reports `reason` 0.
- R11: Consider a start sampled at clock edge E. `busy` is high from E until the `done` pulse. `done` is high for exactly one cycle, following edge E+49. `accept` and `reason` are updated with `done` and hold their values until the next `done`.
- R12: A start strobe that arrives while `busy` is high is ignored. The frame in progress completes with its own result, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Configuration write strobe |
| reg_sel | input | 2 | Write target: 0 pointer, 1 indirect data, 2 mode word |
| reg_wdata | input | 32 | Configuration write data |
| dst_valid | input | 1 | Start strobe for one destination address |
| dst_addr | input | 48 | Destination address, byte k on bits 8k+7:8k |
| busy | output | 1 | A decision is being computed |
| done | output | 1 | One-cycle pulse: decision valid |
| accept | output | 1 | Frame accepted |
| reason | output | 2 | Acceptance reason code |

## Verification
A wrong CRC step or a wrong bit order does not show up as an obvious failure. It moves the hash index, so accept flips on roughly half of the swept multicast addresses at the first `done` after the fault. A table word written to the wrong place has a similar effect: only the addresses that hash into the displaced words are misjudged. The bench therefore sweeps hundreds of multicast addresses against a table model, which catches both kinds of fault. A counter or sequencing fault shows up in the cycle of the first `done`: the pulse comes early, comes late, lasts longer than one cycle, or is repeated after an ignored start.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int          MAC_W    = 48;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam int          HASH_W   = 9;
  localparam int          TBL_BITS = 1 << HASH_W;
  localparam int          WORD_W   = 16;
  localparam int          TBL_WORDS = TBL_BITS / WORD_W;
  localparam int          STA_WORDS = MAC_W / WORD_W;
  localparam int          PTR_W    = 10;
  localparam logic [PTR_W-1:0] TBL_BASE = 10'h200;
  localparam int          CFG_W    = 32;

  // mode word field positions
  localparam int MB_BCAST_HI = 31;
  localparam int MB_BCAST_LO = 30;
  localparam int MB_ALLMC    = 29;
  localparam int MB_ALLUC    = 28;
  localparam int MB_OWN      = 27;
  localparam int MB_HASHMC   = 21;

  typedef enum logic [1:0] {
    RSN_BCAST   = 2'd0,
    RSN_EXACT   = 2'd1,
    RSN_HASH    = 2'd2,
    RSN_PROMISC = 2'd3
  } reason_e;

  typedef struct packed {
    logic bcast;
    logic allmc;
    logic alluc;
    logic own;
    logic hashmc;
  } mode_t;

  // one bit of the reflected CRC, shifting right
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic b);
    crc_step = (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY : '0);
  endfunction

  function automatic mode_t mode_decode(input logic [CFG_W-1:0] w);
    mode_t m;
    m.bcast  = w[MB_BCAST_HI] | w[MB_BCAST_LO];
    m.allmc  = w[MB_ALLMC];
    m.alluc  = w[MB_ALLUC];
    m.own    = w[MB_OWN];
    m.hashmc = w[MB_HASHMC];
    return m;
  endfunction
endpackage

// File: rtl/mcf_cfg_regs.sv
module mcf_cfg_regs
  import mcf_pkg::*;
#(
  parameter int AW = MAC_W,
  parameter int TB = TBL_BITS,
  parameter int WW = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [AW-1:0]    station,
  output logic [TB-1:0]    table_q,
  output mode_t            mode
);
  localparam int NSTA = AW / WW;
  localparam int NTBL = TB / WW;

  logic [PTR_W-1:0] ptr_q;
  logic             data_wr;
  logic [WW-1:0]    wword;

  assign data_wr = reg_wr && (reg_sel == 2'd1);
  assign wword   = reg_wdata[WW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      mode  <= '0;
    end else if (reg_wr) begin
      if (reg_sel == 2'd0) ptr_q <= reg_wdata[PTR_W-1:0];
      if (reg_sel == 2'd2) mode  <= mode_decode(reg_wdata);
    end
  end

  for (genvar s = 0; s < NSTA; s++) begin : g_sta
    logic hit_s;
    assign hit_s = data_wr && (ptr_q == PTR_W'(2*s));
    always_ff @(posedge clk) begin
      if (!rst_n)     station[s*WW +: WW] <= '0;
      else if (hit_s) station[s*WW +: WW] <= wword;
    end
  end

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    logic hit_t;
    assign hit_t = data_wr && (ptr_q == TBL_BASE + PTR_W'(2*t));
    always_ff @(posedge clk) begin
      if (!rst_n)     table_q[t*WW +: WW] <= '0;
      else if (hit_t) table_q[t*WW +: WW] <= wword;
    end
  end

  logic tbl_range;
  assign tbl_range = (ptr_q >= TBL_BASE) && (ptr_q < TBL_BASE + PTR_W'(2*NTBL)) && !ptr_q[0];

  AST_TBL_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tbl_range) |=> (table_q[{$past(ptr_q[5:1]), 4'b0000} +: WW] == $past(wword))); // R3

  AST_STA_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr_q == '0) |=> (station[WW-1:0] == $past(wword))); // R4
endmodule

// File: rtl/mcf_crc_engine.sv
module mcf_crc_engine
  import mcf_pkg::*;
#(
  parameter int AW = MAC_W,
  parameter int HW = HASH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  output logic          busy_q,
  output logic          eval_q,
  output logic [AW-1:0] addr_q,
  output logic [HW-1:0] hash_idx
);
  localparam int CNT_W = $clog2(AW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(AW - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q;
  logic             accept_start;

  assign accept_start = start && !busy_q && !eval_q;
  assign hash_idx     = crc_q[HW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      eval_q <= 1'b0;
      cnt_q  <= '0;
      crc_q  <= '0;
      addr_q <= '0;
    end else begin
      eval_q <= 1'b0;
      if (accept_start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        crc_q  <= '1;
        addr_q <= addr_in;
      end else if (busy_q) begin
        crc_q <= crc_step(crc_q, addr_q[cnt_q]);
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          eval_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q || eval_q) |=> $stable(addr_q)); // R12

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST)); // R11

  AST_EVAL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    eval_q |-> ($past(busy_q) && $past(cnt_q) == LAST)); // R11
endmodule

// File: rtl/mcf_decide.sv
module mcf_decide
  import mcf_pkg::*;
#(
  parameter int AW = MAC_W,
  parameter int HW = HASH_W,
  parameter int TB = TBL_BITS
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] station,
  input  logic [TB-1:0] table_q,
  input  mode_t         mode,
  input  logic [HW-1:0] hash_idx,
  output logic          accept,
  output reason_e       reason
);
  logic is_bcast, is_mc, hash_hit, own_hit;

  assign is_bcast = &addr;
  assign is_mc    = addr[0];
  assign hash_hit = table_q[hash_idx];
  assign own_hit  = (addr == station);

  always_comb begin
    accept = 1'b0;
    reason = RSN_BCAST;
    if (is_bcast) begin
      accept = mode.bcast;
    end else if (is_mc) begin
      if (mode.allmc) begin
        accept = 1'b1;
        reason = RSN_PROMISC;
      end else if (mode.hashmc && hash_hit) begin
        accept = 1'b1;
        reason = RSN_HASH;
      end
    end else begin
      if (mode.alluc) begin
        accept = 1'b1;
        reason = RSN_PROMISC;
      end else if (mode.own && own_hit) begin
        accept = 1'b1;
        reason = RSN_EXACT;
      end
    end
  end

  always_comb begin
    AST_REJECT_REASON_ZERO: assert (accept || reason == RSN_BCAST); // R10
  end
endmodule

// File: rtl/mcf_filter_top.sv
module mcf_filter_top
  import mcf_pkg::*;
#(
  parameter int AW = MAC_W,
  parameter int HW = HASH_W,
  parameter int WW = WORD_W,
  localparam int TB = 1 << HW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [CFG_W-1:0] reg_wdata,
  input  logic             dst_valid,
  input  logic [AW-1:0]    dst_addr,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic [1:0]       reason
);
  logic [AW-1:0] station;
  logic [TB-1:0] table_q;
  mode_t         mode;
  logic          busy_q, eval_q;
  logic [AW-1:0] addr_q;
  logic [HW-1:0] hash_idx;
  logic          dec_accept;
  reason_e       dec_reason;

  mcf_cfg_regs #(.AW(AW), .TB(TB), .WW(WW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .station(station), .table_q(table_q), .mode(mode)
  );

  mcf_crc_engine #(.AW(AW), .HW(HW)) u_crc (
    .clk(clk), .rst_n(rst_n), .start(dst_valid), .addr_in(dst_addr),
    .busy_q(busy_q), .eval_q(eval_q), .addr_q(addr_q), .hash_idx(hash_idx)
  );

  mcf_decide #(.AW(AW), .HW(HW), .TB(TB)) u_dec (
    .addr(addr_q), .station(station), .table_q(table_q), .mode(mode),
    .hash_idx(hash_idx), .accept(dec_accept), .reason(dec_reason)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      accept <= 1'b0;
      reason <= 2'd0;
    end else begin
      done <= eval_q;
      if (eval_q) begin
        accept <= dec_accept;
        reason <= dec_reason;
      end
    end
  end

  assign busy = busy_q | eval_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(accept) && $stable(reason))); // R11

  AST_BCAST_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept && reason == RSN_BCAST) |-> (&addr_q)); // R9

  AST_EXACT_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept && reason == RSN_EXACT) |-> (addr_q == station && !addr_q[0])); // R7

  AST_HASH_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept && reason == RSN_HASH) |-> (addr_q[0] && !(&addr_q))); // R8
endmodule

// File: tb/mcf_filter_top_tb_top.sv
module mcf_filter_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        busy, done, accept;
  logic [1:0]  reason;

  int n_vec = 0;
  int n_bad = 0;

  logic [511:0] m_tbl = '0;
  logic [47:0]  m_sta = '0;
  logic [31:0]  m_mode = '0;

  always #5 clk = ~clk;

  mcf_filter_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .busy(busy), .done(done), .accept(accept), .reason(reason)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // byte-wise form of the reflected CRC
  function automatic logic [8:0] model_hash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      c = c ^ {24'd0, a[8*k +: 8]};
      for (int j = 0; j < 8; j++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[8:0];
  endfunction

  // returns {accept, reason}
  function automatic logic [2:0] model(input logic [47:0] a);
    bit bc = m_mode[31] | m_mode[30];
    if (a == '1) return {bc, 2'd0};
    if (a[0]) begin
      if (m_mode[29]) return 3'b111;
      if (m_mode[21] && m_tbl[model_hash(a)]) return 3'b110;
      return 3'b000;
    end
    if (m_mode[28]) return 3'b111;
    if (m_mode[27] && a == m_sta) return 3'b101;
    return 3'b000;
  endfunction

  task automatic cfg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_mode(input logic [31:0] m);
    cfg(2'd2, m);
    m_mode = m;
  endtask

  // inject: issue a second start this many cycles after the first (0 = none)
  task automatic frame(input logic [47:0] a, input string req, input int inject,
                       output logic acc, output logic [1:0] rsn, output int lat);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a;
    lat = 0;
    do begin
      @(negedge clk);
      dst_valid = 1'b0;
      lat++;
      if (inject != 0 && lat == inject) begin
        dst_valid = 1'b1; dst_addr = ~a;
      end
      if (lat > 1 && lat < 50 && !busy)
        check(1'b0, {req, " busy dropped"}, busy, 1);
    end while (!done && lat < 200);
    acc = accept; rsn = reason;
  endtask

  task automatic run_check(input logic [47:0] a, input string req);
    logic acc; logic [1:0] rsn; int lat;
    logic [2:0] e;
    e = model(a);
    frame(a, req, 0, acc, rsn, lat);
    check({acc, rsn} == e, req, {acc, rsn}, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++; n_vec++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic acc; logic [1:0] rsn; int lat;
    int hits = 0, misses = 0;
    logic [47:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !accept && reason == 0, "R1 reset outputs",
          {busy, done, accept, reason}, 0);
    run_check(48'hFFFF_FFFF_FFFF, "R1 broadcast rejected after reset");
    run_check(48'h0, "R1 zero unicast rejected after reset");
    run_check(48'h0000_0000_0001, "R1 multicast rejected after reset");

    // R11 latency, busy, single done
    frame(48'h1234_5678_9ABC, "R11", 0, acc, rsn, lat);
    check(lat == 50, "R11 done latency", lat, 50);
    @(negedge clk);
    check(!done && !busy, "R11 done one cycle", {done, busy}, 0);

    // R4 station, R3 table load
    m_sta = 48'h4D2E_91C7_35B0;
    for (int w = 0; w < 3; w++) begin
      cfg(2'd0, 32'(2 * w));
      cfg(2'd1, {16'hDEAD, m_sta[16*w +: 16]});
    end
    for (int i = 0; i < 32; i++) begin
      logic [15:0] wv;
      wv = 16'(i * 16'h3B1D) ^ 16'h5A3C;
      cfg(2'd0, 32'h200 + 32'(2 * i));
      cfg(2'd1, {16'h0, wv});
      m_tbl[16*i +: 16] = wv;
    end
    // unlisted pointers: odd, gap, beyond table
    cfg(2'd0, 32'h001); cfg(2'd1, 32'hFFFF);
    cfg(2'd0, 32'h006); cfg(2'd1, 32'hFFFF);
    cfg(2'd0, 32'h240); cfg(2'd1, 32'hFFFF);

    // hashed mode: bcast + own + hash
    set_mode(32'hC820_0000);
    run_check(m_sta, "R4 R7 exact station match");
    for (int j = 0; j < 6; j++)
      run_check(m_sta ^ (48'h2 << (8 * j)), "R7 near-miss unicast rejected");
    run_check(48'hFFFF_FFFF_FFFF, "R9 broadcast accepted");

    // R2 R3 R8 multicast sweep against the table model
    for (int k = 0; k < 300; k++) begin
      a = {16'(k * 16'h9E37), 16'(k * 16'h7F4B) ^ 16'h1234, 8'(k * 3 + 5), 8'(k) | 8'h01};
      if (model(a) == 3'b110) hits++; else misses++;
      run_check(a, "R2 R3 R8 hashed multicast");
    end
    check(hits > 20 && misses > 20, "R2 sweep covers hits and misses", hits, misses);

    // R8 hash flag off: all multicast rejected
    set_mode(32'hC800_0000);
    for (int k = 0; k < 16; k++)
      run_check({40'h0A0B0C0D0E, 8'(k * 16 + 1)}, "R8 R5 hash disabled");
    // R9 broadcast off, other flags set
    set_mode(32'h3820_0000);
    run_check(48'hFFFF_FFFF_FFFF, "R9 broadcast rejected without bit 31/30");
    set_mode(32'h4000_0000);
    run_check(48'hFFFF_FFFF_FFFF, "R9 R5 bit 30 alone accepts broadcast");
    set_mode(32'h8000_0000);
    run_check(48'hFFFF_FFFF_FFFF, "R9 R5 bit 31 alone accepts broadcast");
    run_check(m_sta, "R7 own flag clear rejects station");

    // promiscuous
    set_mode(32'hF800_0000);
    run_check(m_sta, "R10 promiscuous beats exact");
    run_check(48'h1111_2222_3340, "R7 R10 all-unicast");
    run_check(48'h1111_2222_3341, "R8 R10 all-multicast");
    run_check(48'hFFFF_FFFF_FFFF, "R6 R10 broadcast reason 0");
    run_check(48'hFFFF_FFFF_FFFE, "R6 near-broadcast is unicast");
    run_check(48'hFFFF_FFFF_FEFF, "R6 near-broadcast multicast");

    // all-multicast only
    set_mode(32'h2000_0000);
    run_check(48'h0000_0000_0003, "R8 all-multicast accepts");
    run_check(48'h0000_0000_0002, "R7 unicast rejected in all-multicast");

    // R12 start during busy ignored
    set_mode(32'hC820_0000);
    frame(m_sta, "R12", 10, acc, rsn, lat);
    check(lat == 50, "R12 latency unchanged", lat, 50);
    check(acc && rsn == 2'd1, "R12 first frame result", {acc, rsn}, 3'b101);
    begin
      bit extra = 1'b0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (done) extra = 1'b1;
      end
      check(!extra, "R12 no extra done", extra, 0);
    end
    // R11 results hold between frames
    check(accept && reason == 2'd1, "R11 result held", {accept, reason}, 3'b101);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule